// File: doc/BRIEF.md
# Interleaved Two-Phase PWM Generator

This block drives the low-side switch enables of a two-phase interleaved boost stage. Each phase owns a free-running period counter of `CNT_W` bits, so a period lasts `2**CNT_W` clocks. The second phase does not run from a fixed offset. It starts when the first phase's counter MSB is about to go from 0 to 1, which puts it half a period behind phase one. After that both counters free-run in lockstep.

One duty word sets the on-time of both phases. Each phase holds its own copy of the word. That copy is refreshed only when its counter wraps. A phase switches off when its own count reaches the held value, whatever the other phase is doing at that moment. Each output can therefore be set anywhere from off to one clock short of full duty. With a setting above half scale the two on-times overlap.

Top module: `dual_phase_pwm`

## Requirements
- R1: While `rst_n` is low at a clock edge, or `enable` is low, both counters are cleared and held, and after that edge `gate_a` and `gate_b` are low.
- R2: Once running, each phase repeats with a period of exactly `2**CNT_W` clocks.
- R3: Phase A starts on the first edge at which `enable` is sampled high. From that edge each output is high for exactly `duty` clocks after its counter wraps to zero, and low for the rest of the period.
- R4: Phase B stays low and idle until phase A's count MSB rises. Phase B's count-zero edge coincides with phase A's count reaching `2**(CNT_W-1)`, so phase B lags phase A by half a period.
- R5: A `duty` of zero keeps the output low for the entire period.
- R6: The largest `duty`, `2**CNT_W-1`, leaves each output low for exactly one clock per period.
- R7: Each phase samples `duty` only at its own wrap edge, the edge that sets its count to zero. A change at any other time first takes effect at that phase's next wrap, so the output never rises again after it has fallen within one period.
- R8: Both phases use the same `duty` word. With `duty` above `2**(CNT_W-1)` there are clocks in which both outputs are high together.
- R9: Lowering `enable` and raising it again restarts phase A from zero. Phase B stays idle again for the first half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request; low clears and holds both phases |
| duty | input | CNT_W | Shared on-time in clocks per period |
| gate_a | output | 1 | Switch enable, phase A |
| gate_b | output | 1 | Switch enable, phase B |

## Verification
The assertions assume that `enable` and `duty` change only between clock edges. They also assume that after reset the counters move only through the phase logic, so the half-period offset between the two counts is an invariant once both phases are running. The stimulus changes inputs a short time after each rising edge and keeps `duty` within `0` to `2**CNT_W-1`. It deliberately changes `duty` in the middle of a period, to show that the change waits for the next wrap.

// File: rtl/dpwm_pkg.sv
// Shared types for the interleaved PWM generator.
package dpwm_pkg;
    // Run state of one phase counter.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_mode_t;
endpackage

// File: rtl/dpwm_edge.sv
// Predicts a rising edge of a counter MSB.
// fire is high in the cycle whose next clock edge moves the count MSB from 0 to 1.
// Assumes the counter advances by one on every edge while active is high.
module dpwm_edge #(
    parameter int CNT_W = 4
) (
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    output logic             fire
);
    localparam int MSB = CNT_W - 1;

    logic [CNT_W-1:0] cnt_next;

    // Next count value and the MSB transition it implies.
    always_comb begin
        cnt_next = cnt + 1'b1;
        fire     = active && !cnt[MSB] && cnt_next[MSB];
    end
endmodule

// File: rtl/dpwm_phase.sv
// One PWM phase: a free-running period counter, a threshold held per period, and a registered gate.
// The phase starts on the first edge with launch high. The threshold is captured whenever the count
// becomes zero. The gate is high while count < held threshold.
// Assumes thr_in is stable around clock edges.
module dpwm_phase
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             launch,
    input  logic [CNT_W-1:0] thr_in,
    output logic             gate_o,
    output logic             msb_rise_o
);
    phase_mode_t      mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] cnt_step;
    logic             act;

    assign act = (mode_q == PH_RUN);

    // Next sequential count while running.
    always_comb cnt_step = cnt_q + 1'b1;

    // Counter, threshold hold and gate register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            mode_q <= PH_IDLE;
            cnt_q  <= '0;
            thr_q  <= '0;
            gate_o <= 1'b0;
        end else if (!act) begin
            if (launch) begin
                mode_q <= PH_RUN;
                cnt_q  <= '0;
                thr_q  <= thr_in;
                gate_o <= (thr_in != '0);
            end
        end else begin
            cnt_q <= cnt_step;
            if (cnt_step == '0) begin
                thr_q  <= thr_in;
                gate_o <= (thr_in != '0);
            end else begin
                gate_o <= (cnt_step < thr_q);
            end
        end
    end

    // Half-period marker for launching a trailing phase.
    dpwm_edge #(.CNT_W(CNT_W)) u_edge (
        .active (act),
        .cnt    (cnt_q),
        .fire   (msb_rise_o)
    );
endmodule

// File: rtl/dual_phase_pwm.sv
// Two-phase interleaved PWM generator for boost switch enables.
// Phase A starts with enable. Phase B starts when phase A's count MSB rises (half a period later).
// Both phases compare against the same duty word. Assumes inputs change away from clock edges.
module dual_phase_pwm #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] duty,
    output logic             gate_a,
    output logic             gate_b
);
    logic rise_a;
    logic rise_b_unused;

    // Leading phase: launched directly by enable.
    dpwm_phase #(.CNT_W(CNT_W)) u_ph_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .launch     (1'b1),
        .thr_in     (duty),
        .gate_o     (gate_a),
        .msb_rise_o (rise_a)
    );

    // Trailing phase: launched by the leading phase's MSB rise.
    dpwm_phase #(.CNT_W(CNT_W)) u_ph_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .launch     (rise_a),
        .thr_in     (duty),
        .gate_o     (gate_b),
        .msb_rise_o (rise_b_unused)
    );
endmodule

// File: rtl/dpwm_checker.sv
// Temporal checks on the interleaved PWM generator, attached by bind.
// Assumes the phase counters are only changed by the phase logic after reset.
module dpwm_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             gate_a,
    input logic             gate_b,
    input logic             act_a,
    input logic             act_b,
    input logic [CNT_W-1:0] cnt_a,
    input logic [CNT_W-1:0] cnt_b
);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(1 << (CNT_W - 1));
    localparam logic [CNT_W-1:0] TOP  = '1;

    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!gate_a && !gate_b));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && act_a && cnt_a == TOP) |=> (cnt_a == '0));

    p_rise_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_a) |-> (cnt_a == '0));

    p_b_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !act_b |-> !gate_b);

    p_half_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_a && act_b) |-> (cnt_b == CNT_W'(cnt_a - HALF)));

    p_off_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_a && cnt_a == TOP) |-> !gate_a);

    p_no_runt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_a && cnt_a != TOP && !gate_a) |=> !gate_a);
endmodule

bind dual_phase_pwm dpwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .gate_a (gate_a),
    .gate_b (gate_b),
    .act_a  (u_ph_a.act),
    .act_b  (u_ph_b.act),
    .cnt_a  (u_ph_a.cnt_q),
    .cnt_b  (u_ph_b.cnt_q)
);

// File: tb/sim_dual_phase_pwm.sv
// Scoreboard bench: the driver predicts the gates after each edge and queues them, the monitor compares.
module sim_dual_phase_pwm;
    localparam int CNT_W = 4;
    localparam int PER   = 1 << CNT_W;
    localparam int HALF  = PER / 2;

    typedef struct {
        int    due;
        bit    ea;
        bit    eb;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [CNT_W-1:0] duty = '0;
    logic             gate_a;
    logic             gate_b;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    int   overlap_seen = 0;
    exp_t q[$];

    // Model state derived from the requirements.
    bit m_act_a = 0, m_act_b = 0;
    int m_pa = 0, m_pb = 0, m_ta = 0, m_tb = 0;
    bit m_ga = 0, m_gb = 0;

    dual_phase_pwm #(.CNT_W(CNT_W)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .duty   (duty),
        .gate_a (gate_a),
        .gate_b (gate_b)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Predicted gate after a wrap or a running step (R3, R5, R7).
    task automatic step_phase(inout int pos, inout int thr, output bit g, input int d);
        pos = (pos + 1) % PER;
        if (pos == 0) thr = d;
        g = (pos < thr);
    endtask

    // Apply inputs for n edges and queue the expected gates after each.
    task automatic drive(input int n, input bit en, input int d, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            enable = en;
            duty   = CNT_W'(d);
            if (!en) begin
                m_act_a = 0; m_act_b = 0; m_pa = 0; m_pb = 0;
                m_ta = 0; m_tb = 0; m_ga = 0; m_gb = 0;
            end else begin
                bit launch_b;
                launch_b = m_act_a && (m_pa == HALF - 1);
                if (!m_act_a) begin
                    m_act_a = 1; m_pa = 0; m_ta = d; m_ga = (d != 0);
                end else begin
                    step_phase(m_pa, m_ta, m_ga, d);
                end
                if (!m_act_b) begin
                    if (launch_b) begin
                        m_act_b = 1; m_pb = 0; m_tb = d; m_gb = (d != 0);
                    end
                end else begin
                    step_phase(m_pb, m_tb, m_gb, d);
                end
            end
            q.push_back('{due: cyc + 1, ea: m_ga, eb: m_gb, tag: tag});
        end
    endtask

    // Monitor: compare outputs against queued predictions between edges.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (gate_a !== e.ea || gate_b !== e.eb) begin
                n_fail++;
                $display("FAIL %s cycle %0d: gate_a=%0b gate_b=%0b expected %0b %0b",
                         e.tag, cyc, gate_a, gate_b, e.ea, e.eb);
            end
            if (e.tag == "R8" && gate_a && gate_b) overlap_seen++;
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Test sequence.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (gate_a !== 1'b0 || gate_b !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: gates=%0b%0b expected 00", gate_a, gate_b);
        end
        @(posedge clk);
        #2 rst_n = 1'b1;
        drive(4, 0, 5, "R1");
        drive(12, 1, 5, "R4");
        drive(40, 1, 5, "R3");
        drive(3, 1, 12, "R7");
        drive(30, 1, 2, "R7");
        drive(40, 1, 0, "R5");
        drive(40, 1, PER - 1, "R6");
        drive(40, 1, 12, "R8");
        drive(5, 0, 12, "R1");
        drive(24, 1, 3, "R9");
        drive(48, 1, 1, "R2");
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        n_checks++;
        if (overlap_seen == 0) begin
            n_fail++;
            $display("FAIL R8 overlap: both-high cycles=%0d expected >0", overlap_seen);
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule